// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Aligner

This block sits between the memory-access stage of a processor and a data memory organised as 32-bit words. For a store, it turns an access size, a byte address and the register operand into a word address, a per-lane write-enable mask and write data placed on the right byte lanes. For a load, it picks the addressed byte, halfword or word out of the word returned by memory, then sign- or zero-extends it to full width.

Lanes follow big-endian order. Byte offset 0 within a word is the most significant lane, and byte offset 3 is the least significant lane. Halfword accesses must sit on an even address. Word accesses must sit on a multiple of four. An access that breaks its alignment rule raises a flag and is suppressed: no lane is enabled and the load result is zero. The logic has no storage: every output is a function of the present inputs.

Top module: `lsa_be_aligner`

## Requirements
- R1: `mem_addr` equals `req_addr` with its two low bits forced to zero, for every access.
- R2: A byte store (`req_size`=00) at offset k (`req_addr[1:0]`) sets only `mem_be` bit 3−k, where bit 3 is the most significant lane `[31:24]`. `mem_wdata` holds `st_data[7:0]` copied into all four lanes.
- R3: A halfword store (`req_size`=01) sets `mem_be`=1100 at offset 0 and 0011 at offset 2. `mem_wdata` holds `st_data[15:0]` copied into both halves.
- R4: A word store (`req_size`=10) at offset 0 sets `mem_be`=1111, and `mem_wdata` equals `st_data`.
- R5: A byte load at offset k returns `mem_rdata[31-8k:24-8k]`. The value is sign-extended to 32 bits when `req_unsigned`=0 and zero-extended when it is 1.
- R6: A halfword load at offset 0 returns `mem_rdata[31:16]`, and at offset 2 it returns `mem_rdata[15:0]`. The value is sign- or zero-extended under `req_unsigned`.
- R7: An aligned word load returns `mem_rdata` unchanged, whatever `req_unsigned` is.
- R8: A halfword access at an odd offset, or a word access at a nonzero offset, raises `misalign`. It also forces `mem_be` to 0000 and `ld_data` to zero. Byte accesses are never misaligned.
- R9: With `req_en`=0, `misalign`=0, `mem_be`=0000 and `ld_data`=0. A load (`req_store`=0) always leaves `mem_be`=0000.
- R10: Size code 11 behaves exactly like size code 10 (word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_en | input | 1 | Access request active |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend sub-word load result |
| req_addr | input | 32 | Byte address |
| st_data | input | 32 | Register data for a store, right-justified |
| mem_rdata | input | 32 | Word read from memory |
| mem_addr | output | 32 | Word-aligned address to memory |
| mem_be | output | 4 | Lane write enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-positioned write data |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Alignment violation |

## Verification
The block holds no state, so any lane-mapping or extension fault shows on the ports in the same cycle as the request that exposes it. A swapped lane index appears as the wrong byte enable or the wrong extracted byte at a single offset. A wrong sign-extension choice shows only on data whose top selected bit is set. For these reasons the bench drives every size, direction, signedness and offset with data patterns in which that bit is both set and clear. It compares each result against a byte-array model.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // Access size code as seen on req_size
    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } lsa_size_e;

    function automatic logic is_word(input lsa_size_e s);
        return (s == SZ_WORD) || (s == SZ_WORD_ALT);
    endfunction

endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
    import lsa_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  lsa_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             aligned
);

    logic aligned_d;

    always_comb begin
        unique case (size)
            SZ_BYTE:             aligned_d = 1'b1;
            SZ_HALF:             aligned_d = (off[0] == 1'b0);
            SZ_WORD, SZ_WORD_ALT: aligned_d = (off == '0);
            default:             aligned_d = 1'b0;
        endcase
    end

    assign aligned = aligned_d;

    // R8: byte accesses can never be flagged
    always_comb begin
        if (size == SZ_BYTE) begin
            p_byte_always_ok_r8: assert (aligned_d)
                else $error("byte access reported misaligned");
        end
    end

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  lsa_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              active,
    input  logic [DATA_W-1:0] st_data,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);

    logic [LANES-1:0]  be_d;
    logic [DATA_W-1:0] wdata_d;

    // Lane L holds the byte whose address offset is LANES-1-L (big-endian)
    for (genvar L = 0; L < LANES; L++) begin : g_lane
        localparam int ADDR_OFF = LANES - 1 - L;
        always_comb begin
            if (!active) begin
                be_d[L] = 1'b0;
            end else if (size == SZ_BYTE) begin
                be_d[L] = (int'(off) == ADDR_OFF);
            end else if (size == SZ_HALF) begin
                be_d[L] = ((int'(off) >> 1) == (ADDR_OFF >> 1));
            end else begin
                be_d[L] = 1'b1;
            end

            if (size == SZ_BYTE) begin
                wdata_d[L*8 +: 8] = st_data[7:0];
            end else if (size == SZ_HALF) begin
                wdata_d[L*8 +: 8] = st_data[(L % 2)*8 +: 8];
            end else begin
                wdata_d[L*8 +: 8] = st_data[L*8 +: 8];
            end
        end
    end

    assign be    = be_d;
    assign wdata = wdata_d;

    // R2: a byte store enables at most one lane
    always_comb begin
        if (size == SZ_BYTE) begin
            p_byte_onehot_r2: assert ($onehot0(be_d))
                else $error("byte store enabled several lanes");
        end
    end

    // R3: a halfword store enables zero or two lanes
    always_comb begin
        if (size == SZ_HALF) begin
            p_half_two_lanes_r3: assert (($countones(be_d) == 0) || ($countones(be_d) == 2))
                else $error("halfword store lane count wrong");
        end
    end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  lsa_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              uns,
    input  logic              active,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ld
);

    localparam int HALVES = LANES / 2;

    logic [7:0]        byte_sel;
    logic [15:0]       half_sel;
    logic [DATA_W-1:0] ld_d;

    always_comb begin
        byte_sel = rdata[8*(LANES - 1 - int'(off)) +: 8];
        half_sel = rdata[16*(HALVES - 1 - int'(off >> 1)) +: 16];

        if (!active) begin
            ld_d = '0;
        end else if (size == SZ_BYTE) begin
            ld_d = {{(DATA_W-8){byte_sel[7] & ~uns}}, byte_sel};
        end else if (size == SZ_HALF) begin
            ld_d = {{(DATA_W-16){half_sel[15] & ~uns}}, half_sel};
        end else begin
            ld_d = rdata;
        end
    end

    assign ld = ld_d;

    // R5: unsigned byte load leaves upper bits clear
    always_comb begin
        if (active && uns && size == SZ_BYTE) begin
            p_byte_zext_r5: assert (ld_d[DATA_W-1:8] == '0)
                else $error("unsigned byte load not zero-extended");
        end
    end

endmodule

// File: rtl/lsa_be_aligner.sv
module lsa_be_aligner
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              req_en,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] ld_data,
    output logic              misalign
);

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    lsa_size_e        size_d;
    logic [OFF_W-1:0] off_d;
    logic             aligned_d;
    logic             st_active_d;
    logic             ld_active_d;

    always_comb begin
        size_d      = lsa_size_e'(req_size);
        off_d       = req_addr[OFF_W-1:0];
        st_active_d = req_en & req_store & aligned_d;
        ld_active_d = req_en & ~req_store & aligned_d;
        mem_addr    = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        misalign    = req_en & ~aligned_d;
    end

    lsa_align_check #(.OFF_W(OFF_W)) u_chk (
        .size    (size_d),
        .off     (off_d),
        .aligned (aligned_d)
    );

    lsa_store_lane #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_st (
        .size    (size_d),
        .off     (off_d),
        .active  (st_active_d),
        .st_data (st_data),
        .be      (mem_be),
        .wdata   (mem_wdata)
    );

    lsa_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_ld (
        .size   (size_d),
        .off    (off_d),
        .uns    (req_unsigned),
        .active (ld_active_d),
        .rdata  (mem_rdata),
        .ld     (ld_data)
    );

    // R8: a flagged access writes nothing and returns nothing
    always_comb begin
        if (misalign) begin
            p_misalign_quiet_r8: assert (mem_be == '0 && ld_data == '0)
                else $error("misaligned access not suppressed");
        end
    end

    // R9: idle request stays silent
    always_comb begin
        if (!req_en) begin
            p_idle_quiet_r9: assert (!misalign && mem_be == '0 && ld_data == '0)
                else $error("idle request produced activity");
        end
    end

    // R4: an unflagged word store enables every lane
    always_comb begin
        if (req_en && req_store && is_word(lsa_size_e'(req_size)) && !misalign) begin
            p_word_full_be_r4: assert (&mem_be)
                else $error("aligned word store missing lanes");
        end
    end

endmodule

// File: tb/lsa_be_aligner_test.sv
module lsa_be_aligner_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_en = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] ld_data;
    logic        misalign;

    always #2 clk = ~clk;   // 250 MHz

    lsa_be_aligner uut (
        .req_en       (req_en),
        .req_store    (req_store),
        .req_size     (req_size),
        .req_unsigned (req_unsigned),
        .req_addr     (req_addr),
        .st_data      (st_data),
        .mem_rdata    (mem_rdata),
        .mem_addr     (mem_addr),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .ld_data      (ld_data),
        .misalign     (misalign)
    );

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        chk_wdata;
        logic [31:0] ld;
        logic        mis;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // Reference: the memory word viewed as a big-endian byte array
    task automatic drive(input logic en, input logic st, input logic [1:0] sz,
                         input logic un, input logic [31:0] a,
                         input logic [31:0] sd, input logic [31:0] rd);
        exp_t e;
        logic [7:0] m[4];
        int k;
        int n;
        logic ok;
        logic [31:0] v;
        @(posedge clk);
        #1;
        req_en = en; req_store = st; req_size = sz; req_unsigned = un;
        req_addr = a; st_data = sd; mem_rdata = rd;
        for (int i = 0; i < 4; i++) m[i] = rd[31-8*i -: 8];
        k  = int'(a[1:0]);
        n  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        ok = (k % n) == 0;
        e.addr = {a[31:2], 2'b00};
        e.be = 4'b0000;
        e.ld = '0;
        e.mis = en && !ok;
        e.chk_wdata = 1'b0;
        e.wdata = '0;
        if (!en) e.tag = "R9";
        else if (!ok) e.tag = "R8";
        else if (sz == 2'b11) e.tag = "R10";
        else if (st) e.tag = (n == 1) ? "R2" : (n == 2) ? "R3" : "R4";
        else e.tag = (n == 1) ? "R5" : (n == 2) ? "R6" : "R7";
        if (en && ok && st) begin
            for (int i = k; i < k + n; i++) e.be[3-i] = 1'b1;
            e.wdata = (n == 1) ? {4{sd[7:0]}} : (n == 2) ? {2{sd[15:0]}} : sd;
            e.chk_wdata = 1'b1;
        end
        if (en && ok && !st) begin
            v = '0;
            for (int i = k; i < k + n; i++) v = {v[23:0], m[i]};
            if (n == 1 && !un) v = {{24{v[7]}}, v[7:0]};
            if (n == 2 && !un) v = {{16{v[15]}}, v[15:0]};
            e.ld = v;
        end
        exp_q.push_back(e);
    endtask

    // Monitor: sample mid-cycle, compare with the oldest expectation
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (mem_addr !== e.addr) begin
                n_fail++;
                $display("FAIL R1 (%s) mem_addr actual %h expected %h", e.tag, mem_addr, e.addr);
            end else if (mem_be !== e.be) begin
                n_fail++;
                $display("FAIL %s mem_be actual %b expected %b", e.tag, mem_be, e.be);
            end else if (e.chk_wdata && mem_wdata !== e.wdata) begin
                n_fail++;
                $display("FAIL %s mem_wdata actual %h expected %h", e.tag, mem_wdata, e.wdata);
            end else if (ld_data !== e.ld) begin
                n_fail++;
                $display("FAIL %s ld_data actual %h expected %h", e.tag, ld_data, e.ld);
            end else if (misalign !== e.mis) begin
                n_fail++;
                $display("FAIL %s misalign actual %b expected %b", e.tag, misalign, e.mis);
            end
        end
    end

    initial begin
        logic [31:0] pat[4];
        pat[0] = 32'h80F1_7F02;
        pat[1] = 32'h1234_89AB;
        pat[2] = 32'hFF00_00FF;
        pat[3] = 32'h7E81_C33C;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state after reset (R9)
        drive(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 32'h0, 32'h0);
        for (int p = 0; p < 4; p++) begin
            for (int en = 0; en < 2; en++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int sz = 0; sz < 4; sz++) begin
                        for (int un = 0; un < 2; un++) begin
                            for (int k = 0; k < 4; k++) begin
                                drive(en[0], st[0], sz[1:0], un[0],
                                      32'hA000_0000 + 32'(p * 64 + sz * 16) + 32'(k),
                                      pat[(p + 1) % 4], pat[p]);
                            end
                        end
                    end
                end
            end
        end
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule